// File: doc/BRIEF.md
# Linked-List Descriptor DMA Channel

This block is one DMA channel that follows a chain of descriptors kept in memory. Each descriptor occupies eight 32-bit words on a 32-byte boundary. The channel loads the descriptor's link word, byte count, source address, destination address and control word, then copies the data one 32-bit word at a time. Each word is one read of the source followed by one write of the destination. When a node is finished, the channel either follows the link word to the next node or stops. A chain whose last link points back at its first node forms a ring that runs until it is terminated.

Software starts the channel with a pulse on `start` and a descriptor byte address on `start_ptr`. It can pause the channel by lowering `chan_enable` and stop it with a pulse on `abort`. Three one-cycle event outputs report a finished chain, a finished node (only for nodes that request it) and errors. `busy`, `cur_count` and `cur_next` show progress while the channel runs.

Memory is reached through a single word-addressed request port that uses valid/ready. The channel holds `mem_req_valid` and every request field steady until it sees `mem_req_ready`. It keeps at most one read in flight. It accepts a read response on any cycle through `mem_rsp_valid`, which has no ready, and responses return in request order. Write requests get no response.

Top module: `lld_dma_channel`

## Requirements
- R1: After reset, `busy`, all three event outputs, `cur_count`, `cur_next` and `mem_req_valid` are zero.
- R2: Loading a descriptor at byte address D reads the word addresses D/4+0, +4, +5, +6 and +7 in that order. The three reserved words (+1..+3) are never read. The first source read follows these five reads.
- R3: Control word bit 31 set makes the source word address advance by one after each word, and bit 30 does the same for the destination. A side whose bit is clear reuses one fixed address for every word of the node.
- R4: Control word bit 1 set makes `evt_node_done` pulse once after the last write of that node. With bit 1 clear, the node produces no such pulse.
- R5: Link word bit 1 set makes the channel continue at the link address with bit 1 cleared. Bit 1 clear, including a link of zero, ends the chain: `evt_chain_done` pulses and `busy` is low in that same cycle.
- R6: A link that points back to an earlier node repeats the chain without end. `cur_next` shows the link word of the node in progress.
- R7: While `chan_enable` is low, no new word transfer begins and `cur_count` holds its value. Raising it again continues from the same word, with no data lost or repeated.
- R8: `start` while `busy` is high is ignored.
- R9: An `abort` pulse while busy ends the channel at the next word or node boundary without `evt_chain_done` or `evt_error`, and `busy` falls.
- R10: `evt_error` pulses, never together with `evt_chain_done`, and the channel goes idle in these cases: a start address with bits [4:0] nonzero; a followed link whose bits [4:0], ignoring bit 1, are nonzero; or a fetched byte count that is zero, above 0x1FFC or not a multiple of 4. A node with a bad count moves no data.
- R11: A request not yet accepted keeps its valid, address, write flag and write data unchanged. No request is raised while a read response is outstanding.
- R12: `cur_count` shows the node's remaining byte count. It drops by 4 with each accepted write, never exceeds 0x1FFC, and is zero once a node completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, taken only when idle |
| start_ptr | input | ADDR_W | Byte address of the first descriptor |
| chan_enable | input | 1 | Run enable; low pauses between words |
| abort | input | 1 | Terminate pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W-2 | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| busy | output | 1 | Channel active |
| cur_count | output | CNT_W | Remaining bytes of the current node |
| cur_next | output | ADDR_W | Link word of the current node |
| evt_chain_done | output | 1 | Chain ended normally |
| evt_node_done | output | 1 | Flagged node finished |
| evt_error | output | 1 | Bad start address, link or count |

## Verification
A wrong fetch index or field capture shows up at once as a wrong word address in the first five reads after a start, or later as data landing at the wrong destination. Faulty address stepping or count handling corrupts destination memory within one node and leaves `cur_count` nonzero or wraps it. A broken link decode appears at the node boundary, a few cycles after the last write: a missing, extra or misclassified event, or `busy` that does not fall. Pause and abort faults show within one word time, as `cur_count` moving while paused or `busy` staying high after an abort.

// File: rtl/lld_pkg.sv
package lld_pkg;

  localparam int CFG_NODE_EVT = 1;
  localparam int CFG_DST_INC  = 30;
  localparam int CFG_SRC_INC  = 31;
  localparam int FETCH_LAST   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FWAIT,
    ST_GATE,
    ST_RREQ,
    ST_RWAIT,
    ST_WREQ,
    ST_NEND
  } chan_state_e;

  // fetch step 0 reads word 0, steps 1..4 read words 4..7
  function automatic logic [2:0] fetch_word(input logic [2:0] idx);
    return (idx == 3'd0) ? 3'd0 : idx + 3'd3;
  endfunction

endpackage

// File: rtl/lld_addr_step.sv
module lld_addr_step #(
  parameter int WA_W = 30
) (
  input  logic [WA_W-1:0] addr_i,
  input  logic            inc_i,
  output logic [WA_W-1:0] addr_o
);
  assign addr_o = inc_i ? addr_i + WA_W'(1) : addr_i;
endmodule

// File: rtl/lld_link_decode.sv
module lld_link_decode #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 5
) (
  input  logic [ADDR_W-1:0] link_i,
  output logic              follow_o,
  output logic              finish_o,
  output logic              bad_o,
  output logic [ADDR_W-3:0] target_o
);
  logic [ADDR_W-1:0] masked;

  always_comb begin
    masked    = link_i;
    masked[1] = 1'b0;
  end

  assign finish_o = ~link_i[1];
  assign bad_o    = link_i[1] && (masked[ALIGN_BITS-1:0] != '0);
  assign follow_o = link_i[1] && !bad_o;
  assign target_o = masked[ADDR_W-1:2];
endmodule

// File: rtl/lld_node_check.sv
module lld_node_check #(
  parameter logic [31:0] MAX_BYTES = 32'h1FFC
) (
  input  logic [31:0] bytes_i,
  output logic        bad_o
);
  assign bad_o = (bytes_i == 32'd0) || (bytes_i > MAX_BYTES) || (bytes_i[1:0] != 2'b00);
endmodule

// File: rtl/lld_dma_channel.sv
module lld_dma_channel
  import lld_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          CNT_W      = 16,
  parameter logic [31:0] MAX_BYTES  = 32'h1FFC,
  parameter int          ALIGN_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [ADDR_W-1:0]   start_ptr,
  input  logic                chan_enable,
  input  logic                abort,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-3:0]   mem_req_addr,
  output logic [31:0]         mem_req_wdata,
  input  logic                mem_rsp_valid,
  input  logic [31:0]         mem_rsp_data,
  output logic                busy,
  output logic [CNT_W-1:0]    cur_count,
  output logic [ADDR_W-1:0]   cur_next,
  output logic                evt_chain_done,
  output logic                evt_node_done,
  output logic                evt_error
);
  localparam int WA_W = ADDR_W - 2;

  chan_state_e         state_q;
  logic [2:0]          fidx_q;
  logic [WA_W-1:0]     base_q;
  logic [ADDR_W-1:0]   link_q;
  logic [CNT_W-1:0]    count_q;
  logic [WA_W-1:0]     src_q, dst_q;
  logic                node_evt_q, src_inc_q, dst_inc_q;
  logic                node_bad_q;
  logic [31:0]         data_q;
  logic                stop_q;
  logic                stop_now;

  logic [WA_W-1:0]     src_nx, dst_nx;
  logic                link_follow, link_finish, link_bad;
  logic [WA_W-1:0]     link_target;
  logic                cnt_bad;

  lld_addr_step #(.WA_W(WA_W)) u_src_step (
    .addr_i(src_q), .inc_i(src_inc_q), .addr_o(src_nx)
  );
  lld_addr_step #(.WA_W(WA_W)) u_dst_step (
    .addr_i(dst_q), .inc_i(dst_inc_q), .addr_o(dst_nx)
  );

  lld_link_decode #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_link (
    .link_i(link_q), .follow_o(link_follow), .finish_o(link_finish),
    .bad_o(link_bad), .target_o(link_target)
  );

  lld_node_check #(.MAX_BYTES(MAX_BYTES)) u_cnt (
    .bytes_i(mem_rsp_data), .bad_o(cnt_bad)
  );

  assign stop_now = stop_q | abort;

  // memory request, a pure function of the state so it stays put until accepted
  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_addr  = '0;
    unique case (state_q)
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = base_q + WA_W'(fetch_word(fidx_q));
      end
      ST_RREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = src_q;
      end
      ST_WREQ: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_addr  = dst_q;
      end
      default: ;
    endcase
  end

  assign mem_req_wdata = data_q;
  assign busy          = (state_q != ST_IDLE);
  assign cur_count     = count_q;
  assign cur_next      = link_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      fidx_q         <= '0;
      base_q         <= '0;
      link_q         <= '0;
      count_q        <= '0;
      src_q          <= '0;
      dst_q          <= '0;
      node_evt_q     <= 1'b0;
      src_inc_q      <= 1'b0;
      dst_inc_q      <= 1'b0;
      node_bad_q     <= 1'b0;
      data_q         <= '0;
      stop_q         <= 1'b0;
      evt_chain_done <= 1'b0;
      evt_node_done  <= 1'b0;
      evt_error      <= 1'b0;
    end else begin
      evt_chain_done <= 1'b0;
      evt_node_done  <= 1'b0;
      evt_error      <= 1'b0;
      if (abort && state_q != ST_IDLE) stop_q <= 1'b1;

      unique case (state_q)
        ST_IDLE: begin
          stop_q <= 1'b0;
          if (start) begin
            if (start_ptr[ALIGN_BITS-1:0] != '0) begin
              evt_error <= 1'b1;
            end else begin
              base_q  <= start_ptr[ADDR_W-1:2];
              fidx_q  <= '0;
              state_q <= ST_FREQ;
            end
          end
        end

        ST_FREQ: if (mem_req_ready) state_q <= ST_FWAIT;

        ST_FWAIT: if (mem_rsp_valid) begin
          unique case (fidx_q)
            3'd0: link_q <= mem_rsp_data;
            3'd1: begin
              node_bad_q <= cnt_bad;
              count_q    <= cnt_bad ? '0 : mem_rsp_data[CNT_W-1:0];
            end
            3'd2: src_q <= mem_rsp_data[ADDR_W-1:2];
            3'd3: dst_q <= mem_rsp_data[ADDR_W-1:2];
            default: begin
              node_evt_q <= mem_rsp_data[CFG_NODE_EVT];
              src_inc_q  <= mem_rsp_data[CFG_SRC_INC];
              dst_inc_q  <= mem_rsp_data[CFG_DST_INC];
            end
          endcase
          if (fidx_q == 3'(FETCH_LAST)) begin
            if (stop_now) begin
              state_q <= ST_IDLE;
            end else if (node_bad_q) begin
              evt_error <= 1'b1;
              state_q   <= ST_IDLE;
            end else begin
              state_q <= ST_GATE;
            end
          end else begin
            fidx_q  <= fidx_q + 3'd1;
            state_q <= ST_FREQ;
          end
        end

        ST_GATE: begin
          if (stop_now)         state_q <= ST_IDLE;
          else if (chan_enable) state_q <= ST_RREQ;
        end

        ST_RREQ: if (mem_req_ready) state_q <= ST_RWAIT;

        ST_RWAIT: if (mem_rsp_valid) begin
          data_q  <= mem_rsp_data;
          state_q <= ST_WREQ;
        end

        ST_WREQ: if (mem_req_ready) begin
          count_q <= count_q - CNT_W'(4);
          src_q   <= src_nx;
          dst_q   <= dst_nx;
          state_q <= (count_q == CNT_W'(4)) ? ST_NEND : ST_GATE;
        end

        ST_NEND: begin
          evt_node_done <= node_evt_q;
          if (stop_now) begin
            state_q <= ST_IDLE;
          end else if (link_finish) begin
            evt_chain_done <= 1'b1;
            state_q        <= ST_IDLE;
          end else if (link_bad) begin
            evt_error <= 1'b1;
            state_q   <= ST_IDLE;
          end else if (link_follow) begin
            base_q  <= link_target;
            fidx_q  <= '0;
            state_q <= ST_FREQ;
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lld_dma_checker.sv
module lld_dma_checker #(
  parameter int          ADDR_W    = 32,
  parameter int          CNT_W     = 16,
  parameter logic [31:0] MAX_BYTES = 32'h1FFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-3:0] mem_req_addr,
  input logic [31:0]       mem_req_wdata,
  input logic              mem_rsp_valid,
  input logic [CNT_W-1:0]  cur_count,
  input logic              evt_chain_done,
  input logic              evt_error
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_one_outstanding_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_valid |-> !mem_req_valid);

  assert_count_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cur_count) <= MAX_BYTES);

  assert_chain_end_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_chain_done |-> !busy);

  assert_error_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_error |-> (!evt_chain_done && !busy));
endmodule

bind lld_dma_channel lld_dma_checker #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)
) u_lld_dma_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .cur_count(cur_count), .evt_chain_done(evt_chain_done), .evt_error(evt_error)
);

// File: tb/test_lld_dma_channel.sv
`timescale 1ns/1ps
module test_lld_dma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_ptr = '0;
  logic        chan_enable = 1'b1;
  logic        abort = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic [29:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        rdy = 1'b1;
  logic        rsp_v = 1'b0;
  logic [31:0] rsp_d = '0;
  logic        busy;
  logic [15:0] cur_count;
  logic [31:0] cur_next;
  logic        evt_chain_done, evt_node_done, evt_error;

  // host access to the memory model
  logic        hw_we = 1'b0;
  logic [8:0]  hw_addr = '0;
  logic [31:0] hw_data = '0;
  logic        bp = 1'b0;
  logic [7:0]  lfsr = 8'h5A;

  logic [31:0] mem [0:511];
  logic [29:0] rlog [0:63];
  int          rd_n = 0;
  int          n_chain = 0, n_node = 0, n_err = 0;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  lld_dma_channel i_lld_dma_channel (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .chan_enable(chan_enable), .abort(abort),
    .mem_req_valid(mem_req_valid), .mem_req_ready(rdy), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(rsp_v), .mem_rsp_data(rsp_d),
    .busy(busy), .cur_count(cur_count), .cur_next(cur_next),
    .evt_chain_done(evt_chain_done), .evt_node_done(evt_node_done), .evt_error(evt_error)
  );

  always @(posedge clk) begin
    rsp_v <= 1'b0;
    if (hw_we) mem[hw_addr] <= hw_data;
    if (mem_req_valid && rdy) begin
      if (mem_req_write) mem[mem_req_addr[8:0]] <= mem_req_wdata;
      else begin
        rsp_v <= 1'b1;
        rsp_d <= mem[mem_req_addr[8:0]];
        rlog[rd_n[5:0]] <= mem_req_addr;
        rd_n <= rd_n + 1;
      end
    end
    if (evt_chain_done) n_chain <= n_chain + 1;
    if (evt_node_done)  n_node  <= n_node + 1;
    if (evt_error)      n_err   <= n_err + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rdy  <= bp ? lfsr[0] : 1'b1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk);
    hw_we = 1'b1; hw_addr = byte_addr[10:2]; hw_data = d;
  endtask

  task automatic poke_end();
    @(negedge clk);
    hw_we = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] link, input logic [31:0] nb,
                          input logic [31:0] src, input logic [31:0] dst, input logic [31:0] cfg);
    poke(at, link);
    for (int k = 1; k < 4; k++) poke(at + 32'(4*k), 32'hDEAD_BEEF);
    poke(at + 16, nb);
    poke(at + 20, src);
    poke(at + 24, dst);
    poke(at + 28, cfg);
    poke_end();
  endtask

  function automatic logic [31:0] spat(input int tag, input int i);
    return 32'hA000_0000 | 32'(tag << 12) | 32'(i);
  endfunction

  task automatic fill_regions(input int tag);
    for (int i = 0; i < 128; i++) poke(32'h400 + 32'(4*i), spat(tag, i));
    for (int i = 0; i < 128; i++) poke(32'h600 + 32'(4*i), 32'h0);
    poke_end();
  endtask

  task automatic run_from(input logic [31:0] p, input int limit, output bit ok);
    @(negedge clk);
    start = 1'b1; start_ptr = p;
    @(negedge clk);
    start = 1'b0;
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      if (!busy) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  // [15:0] bytes, [16] src inc, [17] dst inc, [18] node event, [19] back-pressure
  localparam logic [31:0] VEC [6] = '{
    32'h0007_0010, 32'h0003_0004, 32'h000D_0028,
    32'h000A_000C, 32'h000F_0040, 32'h0003_01FC
  };

  localparam logic [29:0] FETCH_EXP [6] = '{30'd0, 30'd4, 30'd5, 30'd6, 30'd7, 30'd256};

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired R1 actual=%0d expected=%0d", 150000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail + 1);
    $finish;
  end

  initial begin
    bit ok;
    int sc, sn, se, snap, bad, nw;
    logic [31:0] c1, expw;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_req_valid && cur_count == 0 && cur_next == 0 &&
        !evt_chain_done && !evt_node_done && !evt_error, "R1 reset state",
        {busy, mem_req_valid, evt_error, cur_count}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // table of single-node transfers
    for (int v = 0; v < 6; v++) begin
      logic [31:0] vec;
      logic si, di, ne;
      vec = VEC[v];
      si = vec[16]; di = vec[17]; ne = vec[18];
      bp = vec[19];
      nw = int'(vec[15:0]) / 4;
      fill_regions(v);
      put_desc(32'h000, 32'h0, {16'h0, vec[15:0]}, 32'h400, 32'h600,
               {si, di, 28'h0, ne, 1'b1});
      sc = n_chain; sn = n_node; se = n_err; snap = rd_n;
      run_from(32'h000, 5000, ok);
      chk(ok && (n_chain - sc) == 1, "R5 chain done once", 32'(n_chain - sc), 32'd1);
      chk((n_node - sn) == int'(ne), "R4 node event per flag", 32'(n_node - sn), 32'(ne));
      chk(cur_count == 0, "R12 count zero at end", 32'(cur_count), 32'd0);
      bad = 0;
      if (di) begin
        for (int k = 0; k < nw; k++) begin
          expw = si ? spat(v, k) : spat(v, 0);
          if (mem[384 + k] !== expw) bad++;
        end
        if (nw < 128 && mem[384 + nw] !== 32'h0) bad++;
      end else begin
        expw = si ? spat(v, nw - 1) : spat(v, 0);
        if (mem[384] !== expw) bad++;
        if (mem[385] !== 32'h0) bad++;
      end
      chk(bad == 0, bp ? "R3 R11 data under back-pressure" : "R3 data and address stepping",
          32'(bad), 32'd0);
      if (v == 0) begin
        bad = 0;
        for (int k = 0; k < 6; k++)
          if (rlog[(snap + k) % 64] !== FETCH_EXP[k]) bad++;
        chk(bad == 0, "R2 fetch order", 32'(bad), 32'd0);
      end
    end
    bp = 1'b0;

    // R5 two-node chain
    fill_regions(10);
    put_desc(32'h020, 32'h042, 32'd8, 32'h400, 32'h600, 32'hC000_0003);
    put_desc(32'h040, 32'h000, 32'd8, 32'h420, 32'h620, 32'hC000_0003);
    sc = n_chain; sn = n_node;
    run_from(32'h020, 5000, ok);
    chk(ok && (n_chain - sc) == 1, "R5 two-node chain ends once", 32'(n_chain - sc), 32'd1);
    chk((n_node - sn) == 2, "R4 two node events", 32'(n_node - sn), 32'd2);
    bad = 0;
    for (int k = 0; k < 2; k++) begin
      if (mem[384 + k] !== spat(10, k)) bad++;
      if (mem[392 + k] !== spat(10, 8 + k)) bad++;
    end
    chk(bad == 0, "R5 link followed, both nodes copied", 32'(bad), 32'd0);

    // R7 pause, R8 refused start
    fill_regions(11);
    put_desc(32'h060, 32'h000, 32'h100, 32'h400, 32'h600, 32'hC000_0001);
    put_desc(32'h080, 32'h000, 32'd8, 32'h400, 32'h700, 32'hC000_0001);
    sc = n_chain;
    @(negedge clk); start = 1'b1; start_ptr = 32'h060;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 2000 && cur_count != 16'h100; i++) @(negedge clk);
    for (int i = 0; i < 2000 && cur_count > 16'h0C0; i++) @(negedge clk);
    chan_enable = 1'b0;
    repeat (6) @(negedge clk);
    c1 = 32'(cur_count);
    chk(c1[1:0] == 2'b00 && c1 < 32'h100 && c1 > 0, "R12 remaining count mid-node", c1, 32'h0C0);
    @(negedge clk); start = 1'b1; start_ptr = 32'h080;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy && 32'(cur_count) == c1, "R7 count held while paused", 32'(cur_count), c1);
    chan_enable = 1'b1;
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    @(negedge clk);
    bad = 0;
    for (int k = 0; k < 64; k++) if (mem[384 + k] !== spat(11, k)) bad++;
    chk(bad == 0 && !busy, "R7 resume completes without loss", 32'(bad), 32'd0);
    chk((n_chain - sc) == 1 && mem[448] === 32'h0 && mem[449] === 32'h0,
        "R8 start while busy ignored", 32'(n_chain - sc), 32'd1);

    // R6 cyclic ring, R9 abort
    put_desc(32'h0A0, 32'h0C2, 32'd8, 32'h400, 32'h600, 32'hC000_0003);
    put_desc(32'h0C0, 32'h0A2, 32'd8, 32'h410, 32'h610, 32'hC000_0003);
    sc = n_chain; sn = n_node; se = n_err;
    @(negedge clk); start = 1'b1; start_ptr = 32'h0A0;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3000 && (n_node - sn) < 5; i++) @(negedge clk);
    chk((n_node - sn) >= 5 && busy, "R6 ring keeps running", 32'(n_node - sn), 32'd5);
    chk(cur_next == 32'h0C2 || cur_next == 32'h0A2, "R6 current link visible", cur_next, 32'h0C2);
    abort = 1'b1; @(negedge clk); abort = 1'b0;
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    @(negedge clk);
    chk(!busy && n_chain == sc && n_err == se, "R9 abort stops quietly",
        {busy, 15'h0, 16'(n_chain - sc)}, 32'h0);

    // R10 error cases
    put_desc(32'h0E0, 32'h032, 32'd4, 32'h400, 32'h600, 32'hC000_0001);
    sc = n_chain; se = n_err;
    run_from(32'h0E0, 2000, ok);
    chk(ok && (n_err - se) == 1 && n_chain == sc, "R10 misaligned link", 32'(n_err - se), 32'd1);

    poke(32'h600, 32'h1234_5678); poke_end();
    put_desc(32'h000, 32'h0, 32'd0, 32'h400, 32'h600, 32'hC000_0001);
    se = n_err;
    run_from(32'h000, 2000, ok);
    chk(ok && (n_err - se) == 1 && mem[384] === 32'h1234_5678, "R10 zero count moves nothing",
        mem[384], 32'h1234_5678);

    put_desc(32'h000, 32'h0, 32'h2000, 32'h400, 32'h600, 32'hC000_0001);
    se = n_err;
    run_from(32'h000, 2000, ok);
    chk(ok && (n_err - se) == 1 && cur_count == 0, "R10 count above 0x1FFC", 32'(n_err - se), 32'd1);

    put_desc(32'h000, 32'h0, 32'd6, 32'h400, 32'h600, 32'hC000_0001);
    se = n_err;
    run_from(32'h000, 2000, ok);
    chk(ok && (n_err - se) == 1, "R10 count not multiple of 4", 32'(n_err - se), 32'd1);

    se = n_err; snap = rd_n;
    run_from(32'h004, 20, ok);
    chk(ok && (n_err - se) == 1 && rd_n == snap, "R10 misaligned start", 32'(n_err - se), 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule